// File: doc/BRIEF.md
# Disk Interrupt Status Block Handler

This block services one interrupt from a disk attachment at a time. While idle it watches the attachment's pending-interrupt flag. When the flag is set it reads the interrupt status byte once, and that read clears the condition in the attachment. From the byte it takes a drive number and an interrupt code. It then checks whether the attachment is offering a status block. If a block is offered, the handler pulls it in word by word over a valid/ready stream. The first word gives the block length, and every word lands in an eight-entry buffer.

With the block in hand, the handler acts on the interrupt code. Depending on the code it does one of four things: it starts a DMA transfer by writing the attachment control byte, it pulses done, it pulses error, or it raises a fatal strobe. For most codes it then holds an end-of-interrupt request towards the attention sequencer until that sequencer acknowledges. Driver logic reads the status buffer, the residual block count and the last processed block address from the outputs.

The status stream follows plain valid/ready rules. A word moves on a clock edge where `sw_valid_i` and `sw_ready_o` are both high. The producer must hold `sw_data_i` steady while `sw_valid_i` is high and ready is low. `sw_ready_o` is high only while a block is being fetched, so at all other times the producer is held off.

Top module: `disk_irq_handler`

## Requirements
- R1: While `irq_flag_i` is low in the idle state, the block does not read the status byte, does not take status words and pulses no strobe. When the flag is high, `isr_rd_o` is high for exactly one cycle.
- R2: Bits 7:5 of the status byte are the drive number and bits 3:0 are the interrupt code. Both are given out unchanged on `eoi_dev_o` and `eoi_id_o`.
- R3: A status block is fetched only if `sw_valid_i` is high in the cycle just after the status byte read. The first word's bits 15:8 give the length L. After the first word, max(L,1)-1 more words are taken. If no block is offered, the buffer keeps its previous contents.
- R4: After a block is fetched, buffer entry 0 holds the first word. Entries 1..min(L,8)-1 hold the following words in order, and every other entry reads zero.
- R5: If L is above 8, the handler stores the first eight words, reads and discards the rest, and pulses `ovf_o` once.
- R6: Interrupt code 11 (transfer ready) produces one `ctl_wr_o` pulse with `ctl_data_o` = 0x03 (bit 0 interrupt enable, bit 1 DMA enable). It produces no done, no error and no end-of-interrupt request.
- R7: Codes 1, 3, 5 and 8 each pulse `done_o` once.
- R8: Codes 9 and 10 pulse no done, error or fatal strobe, but they still request end-of-interrupt.
- R9: Code 15 pulses `fatal_o` once and makes no end-of-interrupt request.
- R10: Every other code (0, 2, 4, 6, 7, 12, 13, 14) pulses `err_o` once. At most one of done, error, fatal and control write is high in any cycle.
- R11: For every code except 11 and 15, `eoi_req_o` rises after the outcome strobe. It stays high, with a stable drive number and code, until `eoi_ack_i`, and then falls.
- R12: `resid_o` loads buffer entry 3 when all three of these hold: a block was fetched, the command code in bits 4:0 of word 0 is 1 (read) or 2 (write), and the interrupt code is not 11. Otherwise `resid_o` keeps its value.
- R13: `last_rba_o` equals {entry 5, entry 4} of the buffer.
- R14: After reset every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_flag_i | input | 1 | Attachment interrupt pending flag |
| isr_rd_o | output | 1 | Status byte read strobe |
| isr_data_i | input | 8 | Status byte, valid while `isr_rd_o` is high |
| sw_valid_i | input | 1 | Status word offered |
| sw_ready_o | output | 1 | Handler accepts a status word |
| sw_data_i | input | 16 | Status word |
| ctl_wr_o | output | 1 | Control byte write strobe |
| ctl_data_o | output | 8 | Control byte value |
| done_o | output | 1 | Command completed strobe |
| err_o | output | 1 | Command error strobe |
| fatal_o | output | 1 | Attention error strobe |
| ovf_o | output | 1 | Status block length overflow strobe |
| eoi_req_o | output | 1 | End-of-interrupt request to the attention sequencer |
| eoi_ack_i | input | 1 | End-of-interrupt acknowledge |
| eoi_dev_o | output | 3 | Drive number of the serviced interrupt |
| eoi_id_o | output | 4 | Interrupt code of the serviced interrupt |
| sb_words_o | output | 128 | Status buffer, entry n at bits 16n+15:16n |
| resid_o | output | 16 | Residual block count |
| last_rba_o | output | 32 | Last processed block address |

## Verification
Block lengths 0, 1, 3, 8 and 10 are each fed with random gaps between words. These cases separate correct zero-filling from stale entries and show whether the length counter stops at the right word. Interrupt codes are swept across all sixteen values, with and without a block offered. This separates the done, quiet, fatal, transfer and error paths. It also shows which codes must request end-of-interrupt and whether the residual count loads. Acknowledge delays from zero to three cycles show whether the request is held. A flag-low stretch with a word waiting shows that nothing is claimed or taken.

// File: rtl/disk_irq_pkg.sv
package disk_irq_pkg;
  localparam int ID_W    = 4;
  localparam int DEV_W   = 3;
  localparam int DEV_LSB = 5;

  localparam logic [ID_W-1:0] ID_OK       = 4'd1;
  localparam logic [ID_W-1:0] ID_OK_ECC   = 4'd3;
  localparam logic [ID_W-1:0] ID_OK_RETRY = 4'd5;
  localparam logic [ID_W-1:0] ID_OK_WARN  = 4'd8;
  localparam logic [ID_W-1:0] ID_ABORT    = 4'd9;
  localparam logic [ID_W-1:0] ID_RESET    = 4'd10;
  localparam logic [ID_W-1:0] ID_XFER     = 4'd11;
  localparam logic [ID_W-1:0] ID_ATTN     = 4'd15;

  localparam logic [4:0] CMD_READ  = 5'd1;
  localparam logic [4:0] CMD_WRITE = 5'd2;

  // control byte: bit 0 interrupt enable, bit 1 DMA enable
  localparam logic [7:0] CTL_XFER_GO = 8'h03;

  typedef enum logic [2:0] {
    CLS_DONE, CLS_XFER, CLS_QUIET, CLS_FATAL, CLS_FAIL
  } irq_class_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ISR, ST_SBCHK, ST_SBMORE, ST_DISP, ST_EOI
  } hst_e;
endpackage

// File: rtl/disk_irq_classify.sv
module disk_irq_classify
  import disk_irq_pkg::*;
(
  input  logic [ID_W-1:0] id_i,
  output irq_class_e      cls_o,
  output logic            eoi_o
);
  always_comb begin
    case (id_i)
      ID_OK, ID_OK_ECC, ID_OK_RETRY, ID_OK_WARN: cls_o = CLS_DONE;
      ID_XFER:                                   cls_o = CLS_XFER;
      ID_ABORT, ID_RESET:                        cls_o = CLS_QUIET;
      ID_ATTN:                                   cls_o = CLS_FATAL;
      default:                                   cls_o = CLS_FAIL;
    endcase
    eoi_o = (cls_o != CLS_XFER) && (cls_o != CLS_FATAL);
  end
endmodule

// File: rtl/disk_sb_collect.sv
module disk_sb_collect #(
  parameter int DEPTH  = 8,
  parameter int WORD_W = 16,
  parameter int LEN_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take_first,
  input  logic                    take_next,
  input  logic [WORD_W-1:0]       word_i,
  output logic [DEPTH*WORD_W-1:0] buf_o,
  output logic                    first_only_o,
  output logic                    last_o,
  output logic                    ovf_o,
  output logic [4:0]              cmd_o
);
  localparam int IDX_W = $clog2(DEPTH + 1);

  logic [LEN_W-1:0] len_w;
  logic [LEN_W-1:0] need_q;
  logic [IDX_W-1:0] idx_q;
  logic             ovf_q;
  logic [4:0]       cmd_q;

  assign len_w        = word_i[WORD_W-1 -: LEN_W];
  assign first_only_o = (len_w <= LEN_W'(1));
  assign last_o       = (need_q == LEN_W'(1));
  assign ovf_o        = ovf_q;
  assign cmd_o        = cmd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      need_q <= '0;
      idx_q  <= '0;
      ovf_q  <= 1'b0;
      cmd_q  <= '0;
    end else if (take_first) begin
      need_q <= (len_w == '0) ? '0 : len_w - LEN_W'(1);
      idx_q  <= IDX_W'(1);
      ovf_q  <= (len_w > LEN_W'(DEPTH));
      cmd_q  <= word_i[4:0];
    end else if (take_next) begin
      need_q <= need_q - LEN_W'(1);
      if (idx_q < IDX_W'(DEPTH)) idx_q <= idx_q + IDX_W'(1);
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic [WORD_W-1:0] ent_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        ent_q <= '0;
      else if (take_first)
        ent_q <= (e == 0) ? word_i : '0;
      else if (take_next && idx_q == IDX_W'(e))
        ent_q <= word_i;
    end
    assign buf_o[e*WORD_W +: WORD_W] = ent_q;
  end
endmodule

// File: rtl/disk_irq_ctrl.sv
module disk_irq_ctrl
  import disk_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq_flag_i,
  input  logic [7:0]       isr_data_i,
  input  logic             sw_valid_i,
  input  logic             first_only_i,
  input  logic             last_i,
  input  logic             eoi_need_i,
  input  logic             eoi_ack_i,
  output logic             isr_rd_o,
  output logic             sw_ready_o,
  output logic             take_first_o,
  output logic             take_next_o,
  output logic             disp_o,
  output logic             eoi_req_o,
  output logic             blk_o,
  output logic [DEV_W-1:0] dev_o,
  output logic [ID_W-1:0]  id_o
);
  hst_e st_q, st_n;
  logic spare_unused;

  assign spare_unused = isr_data_i[4];

  always_comb begin
    st_n = st_q;
    case (st_q)
      ST_IDLE:   if (irq_flag_i) st_n = ST_ISR;
      ST_ISR:    st_n = ST_SBCHK;
      ST_SBCHK:  st_n = (sw_valid_i && !first_only_i) ? ST_SBMORE : ST_DISP;
      ST_SBMORE: if (sw_valid_i && last_i) st_n = ST_DISP;
      ST_DISP:   st_n = eoi_need_i ? ST_EOI : ST_IDLE;
      ST_EOI:    if (eoi_ack_i) st_n = ST_IDLE;
      default:   st_n = ST_IDLE;
    endcase
  end

  assign isr_rd_o     = (st_q == ST_ISR);
  assign sw_ready_o   = (st_q == ST_SBCHK) || (st_q == ST_SBMORE);
  assign take_first_o = (st_q == ST_SBCHK) && sw_valid_i;
  assign take_next_o  = (st_q == ST_SBMORE) && sw_valid_i;
  assign disp_o       = (st_q == ST_DISP);
  assign eoi_req_o    = (st_q == ST_EOI);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      blk_o <= 1'b0;
      dev_o <= '0;
      id_o  <= '0;
    end else begin
      st_q <= st_n;
      if (st_q == ST_ISR) begin
        dev_o <= isr_data_i[DEV_LSB +: DEV_W];
        id_o  <= isr_data_i[ID_W-1:0];
        blk_o <= 1'b0;
      end else if (take_first_o) begin
        blk_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/disk_irq_handler.sv
module disk_irq_handler
  import disk_irq_pkg::*;
#(
  parameter int SB_DEPTH   = 8,
  parameter int WORD_W     = 16,
  parameter int RESID_IDX  = 3,
  parameter int RBA_LO_IDX = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       irq_flag_i,
  output logic                       isr_rd_o,
  input  logic [7:0]                 isr_data_i,
  input  logic                       sw_valid_i,
  output logic                       sw_ready_o,
  input  logic [WORD_W-1:0]          sw_data_i,
  output logic                       ctl_wr_o,
  output logic [7:0]                 ctl_data_o,
  output logic                       done_o,
  output logic                       err_o,
  output logic                       fatal_o,
  output logic                       ovf_o,
  output logic                       eoi_req_o,
  input  logic                       eoi_ack_i,
  output logic [DEV_W-1:0]           eoi_dev_o,
  output logic [ID_W-1:0]            eoi_id_o,
  output logic [SB_DEPTH*WORD_W-1:0] sb_words_o,
  output logic [WORD_W-1:0]          resid_o,
  output logic [2*WORD_W-1:0]        last_rba_o
);
  logic       take_first, take_next, first_only, last_word, sb_ovf;
  logic       disp, blk, eoi_need;
  logic [4:0] cmd;
  irq_class_e cls;
  logic [WORD_W-1:0] resid_q;

  disk_irq_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .irq_flag_i   (irq_flag_i),
    .isr_data_i   (isr_data_i),
    .sw_valid_i   (sw_valid_i),
    .first_only_i (first_only),
    .last_i       (last_word),
    .eoi_need_i   (eoi_need),
    .eoi_ack_i    (eoi_ack_i),
    .isr_rd_o     (isr_rd_o),
    .sw_ready_o   (sw_ready_o),
    .take_first_o (take_first),
    .take_next_o  (take_next),
    .disp_o       (disp),
    .eoi_req_o    (eoi_req_o),
    .blk_o        (blk),
    .dev_o        (eoi_dev_o),
    .id_o         (eoi_id_o)
  );

  disk_sb_collect #(.DEPTH(SB_DEPTH), .WORD_W(WORD_W), .LEN_W(8)) u_sb (
    .clk          (clk),
    .rst_n        (rst_n),
    .take_first   (take_first),
    .take_next    (take_next),
    .word_i       (sw_data_i),
    .buf_o        (sb_words_o),
    .first_only_o (first_only),
    .last_o       (last_word),
    .ovf_o        (sb_ovf),
    .cmd_o        (cmd)
  );

  disk_irq_classify u_cls (
    .id_i  (eoi_id_o),
    .cls_o (cls),
    .eoi_o (eoi_need)
  );

  assign done_o     = disp && (cls == CLS_DONE);
  assign err_o      = disp && (cls == CLS_FAIL);
  assign fatal_o    = disp && (cls == CLS_FATAL);
  assign ctl_wr_o   = disp && (cls == CLS_XFER);
  assign ctl_data_o = ctl_wr_o ? CTL_XFER_GO : '0;
  assign ovf_o      = disp && blk && sb_ovf;

  always_ff @(posedge clk) begin
    if (!rst_n)
      resid_q <= '0;
    else if (disp && blk && (cmd == CMD_READ || cmd == CMD_WRITE) && cls != CLS_XFER)
      resid_q <= sb_words_o[RESID_IDX*WORD_W +: WORD_W];
  end

  assign resid_o    = resid_q;
  assign last_rba_o = sb_words_o[RBA_LO_IDX*WORD_W +: 2*WORD_W];
endmodule

// File: rtl/disk_irq_handler_chk.sv
module disk_irq_handler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       irq_flag_i,
  input logic       isr_rd_o,
  input logic       ctl_wr_o,
  input logic       done_o,
  input logic       err_o,
  input logic       fatal_o,
  input logic       eoi_req_o,
  input logic       eoi_ack_i,
  input logic [2:0] eoi_dev_o,
  input logic [3:0] eoi_id_o
);
  // R1
  claim_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_rd_o |-> $past(irq_flag_i));

  // R1
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    isr_rd_o |=> !isr_rd_o);

  // R10
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o, fatal_o, ctl_wr_o}));

  // R9
  fatal_no_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_o |=> !eoi_req_o);

  // R6
  xfer_no_eoi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr_o |=> !eoi_req_o);

  // R11
  eoi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req_o && !eoi_ack_i) |=> (eoi_req_o && $stable(eoi_id_o) && $stable(eoi_dev_o)));

  // R11
  eoi_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_req_o && eoi_ack_i) |=> !eoi_req_o);
endmodule

bind disk_irq_handler disk_irq_handler_chk u_chk (.*);

// File: tb/tb_disk_irq_handler.sv
`timescale 1ns/1ps
module tb_disk_irq_handler;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         irq_flag_i = 1'b0;
  logic         isr_rd_o;
  logic [7:0]   isr_data_i = '0;
  logic         sw_valid_i = 1'b0;
  logic         sw_ready_o;
  logic [15:0]  sw_data_i = '0;
  logic         ctl_wr_o;
  logic [7:0]   ctl_data_o;
  logic         done_o, err_o, fatal_o, ovf_o, eoi_req_o;
  logic         eoi_ack_i = 1'b0;
  logic [2:0]   eoi_dev_o;
  logic [3:0]   eoi_id_o;
  logic [127:0] sb_words_o;
  logic [15:0]  resid_o;
  logic [31:0]  last_rba_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;
  logic [15:0] exp_buf [8];
  logic [15:0] exp_resid = '0;

  always #4 clk = ~clk;

  disk_irq_handler dut (.*);

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int cls_of(input logic [3:0] id);
    case (id)
      4'd1, 4'd3, 4'd5, 4'd8: return 0;
      4'd11:                  return 1;
      4'd9, 4'd10:            return 2;
      4'd15:                  return 3;
      default:                return 4;
    endcase
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      0: return "R7";
      1: return "R6";
      2: return "R8";
      3: return "R9";
      default: return "R10";
    endcase
  endfunction

  function automatic logic [127:0] pack_buf();
    logic [127:0] p;
    for (int i = 0; i < 8; i++) p[i*16 +: 16] = exp_buf[i];
    return p;
  endfunction

  task automatic service(input logic [3:0] id, input logic [2:0] dev, input bit blk,
                         input int len, input logic [4:0] cmd, input int ack_dly);
    logic [15:0] wv [16];
    int n_done = 0, n_err = 0, n_fat = 0, n_ctl = 0, n_ovf = 0, n_eoi = 0;
    logic [7:0] ctl_seen = '0;
    logic [2:0] edev = '0;
    logic [3:0] eid = '0;
    int nw, c;
    logic [3:0] exp_strb;
    nw = blk ? ((len < 1) ? 1 : len) : 0;
    wv[0] = {8'(len), 3'($urandom), cmd};
    for (int i = 1; i < 16; i++) wv[i] = 16'($urandom);
    if (blk) begin
      exp_buf[0] = wv[0];
      for (int i = 1; i < 8; i++) exp_buf[i] = (i < len) ? wv[i] : 16'h0;
      if ((cmd == 5'd1 || cmd == 5'd2) && id != 4'd11) exp_resid = exp_buf[3];
    end
    c = cls_of(id);
    isr_data_i = {dev, 1'($urandom), id};
    if (blk) begin sw_valid_i = 1'b1; sw_data_i = wv[0]; end
    irq_flag_i = 1'b1;
    while (!isr_rd_o) @(negedge clk);
    irq_flag_i = 1'b0;
    fork
      begin
        if (blk) begin
          while (!sw_ready_o) @(negedge clk);
          @(negedge clk);
          sw_valid_i = 1'b0;
          for (int i = 1; i < nw; i++) begin
            repeat ($urandom % 3) @(negedge clk);
            sw_valid_i = 1'b1;
            sw_data_i  = wv[i];
            while (!sw_ready_o) @(negedge clk);
            @(negedge clk);
            sw_valid_i = 1'b0;
          end
        end
      end
      begin
        int dly = ack_dly;
        bit acked = 0;
        bit seen = 0;
        for (int k = 0; k < 70; k++) begin
          @(negedge clk);
          if (done_o)  n_done++;
          if (err_o)   n_err++;
          if (fatal_o) n_fat++;
          if (ovf_o)   n_ovf++;
          if (ctl_wr_o) begin n_ctl++; ctl_seen = ctl_data_o; end
          if (eoi_ack_i) eoi_ack_i = 1'b0;
          else if (eoi_req_o && !acked) begin
            if (!seen) begin seen = 1; edev = eoi_dev_o; eid = eoi_id_o; end
            if (dly == 0) begin eoi_ack_i = 1'b1; acked = 1; n_eoi++; end
            else dly--;
          end
        end
      end
    join
    exp_strb = {c == 0, c == 4, c == 3, c == 1};
    check({n_done == 1, n_err == 1, n_fat == 1, n_ctl == 1} == exp_strb &&
          n_done + n_err + n_fat + n_ctl == ((c == 2) ? 0 : 1),
          tag_of(c), "outcome strobes {done,err,fatal,ctl}",
          128'({4'(n_done), 4'(n_err), 4'(n_fat), 4'(n_ctl)}),
          128'({3'b0, exp_strb[3], 3'b0, exp_strb[2], 3'b0, exp_strb[1], 3'b0, exp_strb[0]}));
    check(n_eoi == ((c == 1 || c == 3) ? 0 : 1) && !eoi_req_o, "R11", "eoi count",
          128'(n_eoi), 128'((c == 1 || c == 3) ? 0 : 1));
    if (c != 1 && c != 3)
      check({edev, eid} == {dev, id}, "R2", "eoi dev/id", 128'({edev, eid}), 128'({dev, id}));
    if (c == 1)
      check(ctl_seen == 8'h03, "R6", "control byte", 128'(ctl_seen), 128'h03);
    check(n_ovf == ((blk && len > 8) ? 1 : 0), "R5", "overflow strobes",
          128'(n_ovf), 128'((blk && len > 8) ? 1 : 0));
    check(sb_words_o == pack_buf(), (blk && len < 8) ? "R4" : "R3", "status buffer",
          sb_words_o, pack_buf());
    check(resid_o == exp_resid, "R12", "residual count", 128'(resid_o), 128'(exp_resid));
    check(last_rba_o == {exp_buf[5], exp_buf[4]}, "R13", "last block address",
          128'(last_rba_o), 128'({exp_buf[5], exp_buf[4]}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int u_isr, u_pop, u_str;
    logic [3:0] rid;
    int rlen, pick;
    logic [4:0] rcmd;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 8; i++) exp_buf[i] = '0;
    repeat (4) @(negedge clk);
    // R14 reset state
    check({isr_rd_o, sw_ready_o, ctl_wr_o, ctl_data_o, done_o, err_o, fatal_o, ovf_o,
           eoi_req_o, eoi_dev_o, eoi_id_o} == '0 && sb_words_o == '0 && resid_o == '0 &&
          last_rba_o == '0, "R14", "outputs in reset", 128'(sb_words_o), 128'h0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 unclaimed: flag low, word waiting
    u_isr = 0; u_pop = 0; u_str = 0;
    sw_valid_i = 1'b1;
    sw_data_i = 16'h0512;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (isr_rd_o) u_isr++;
      if (sw_ready_o) u_pop++;
      if (done_o || err_o || fatal_o || ctl_wr_o || eoi_req_o) u_str++;
    end
    sw_valid_i = 1'b0;
    check(u_isr == 0 && u_pop == 0 && u_str == 0 && sb_words_o == '0, "R1",
          "idle activity with flag low", 128'({8'(u_isr), 8'(u_pop), 8'(u_str)}), 128'h0);

    service(4'd1,  3'd0, 1, 6,  5'd1, 0);   // read completed
    service(4'd11, 3'd1, 0, 0,  5'd0, 0);   // transfer ready, no block
    service(4'd11, 3'd1, 1, 5,  5'd1, 1);   // transfer ready with block: residual held
    service(4'd15, 3'd7, 0, 0,  5'd0, 0);   // attention error
    service(4'd10, 3'd7, 1, 2,  5'd4, 2);   // reset completed
    service(4'd9,  3'd2, 0, 0,  5'd0, 3);   // aborted, buffer unchanged
    service(4'd0,  3'd3, 1, 3,  5'd2, 0);   // reserved code -> error
    service(4'd12, 3'd1, 1, 4,  5'd2, 1);   // failure
    service(4'd3,  3'd0, 1, 0,  5'd1, 0);   // length zero
    service(4'd8,  3'd5, 1, 8,  5'd2, 2);   // exactly full buffer
    service(4'd5,  3'd6, 1, 10, 5'd1, 1);   // overflow
    service(4'd14, 3'd4, 1, 1,  5'd9, 0);   // length one

    for (int n = 0; n < 60; n++) begin
      rid  = 4'($urandom);
      rlen = int'($urandom % 11);
      pick = int'($urandom % 3);
      rcmd = (pick == 0) ? 5'd1 : (pick == 1) ? 5'd2 : 5'($urandom);
      service(rid, 3'($urandom), ($urandom % 5) != 0, rlen, rcmd, int'($urandom % 4));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule